// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block takes four asynchronous interrupt request pins from outside the chip and turns each one into a clean request toward a downstream interrupt controller. Each pin is first brought into the clock domain through a short synchroniser. It is then judged by its own sense setting: high level, low level, rising edge or falling edge. An edge is held in a latch until software clears it. A level follows the pin.

All configuration sits in one 32-bit control word on a simple register port. The word holds the per-pin enables, a master enable, the four 2-bit sense codes, the four write-one-to-clear bits and a bit that routes a critical-class request. A read of the clear bits returns the live condition of each pin.

Each pin is handled by a small state machine with three states:
- `PIN_IDLE`: no request.
- `PIN_LATCHED`: an edge has been captured.
- `PIN_LEVEL`: the configured level is present.

The transitions are:
- IDLE to LATCHED: a qualifying edge in an edge mode.
- LATCHED to IDLE: a write-one clear with no new edge in the same cycle.
- IDLE or LATCHED to LEVEL: the active level is seen in a level mode.
- LEVEL to IDLE: the level goes away, or the pin is switched to an edge mode without an edge.
- Any state to LATCHED: an edge arrives in an edge mode; this takes priority over a clear in the same cycle.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After the synchronous active-high reset, the control word reads 0 (with all pins low), every enable is off, every sense code is 00 and no request output is high.
- R2: Sense code 00 (pin i's field at bits 23-2i:22-2i) is level active high. The pin's request follows the pin level three clock edges after the pin changes.
- R3: Sense code 01 is rising edge. A 0-to-1 change on the pin latches a request that stays high after the pin falls again.
- R4: Sense code 10 is falling edge. A rising change does not set the latch, and a 1-to-0 change does.
- R5: Sense code 11 is level active low. The request is high while the pin is low and drops after the pin rises.
- R6: Writing 1 to bit 27-i clears pin i's latched edge request in the cycle after the write. Writing 0 to that bit leaves the latch unchanged.
- R7: Bit 11-i enables pin i's request output. With the enable at 0, the output stays low but the latch still holds and reads back.
- R8: Bit 12 is the master enable. With it at 0, all four request outputs are low whatever the per-pin state.
- R9: Reading bits 27:24 returns the state of pins 0 to 3 (bit 27 is pin 0). A 1 means latched or level-active. Every other bit reads back as last written.
- R10: Bit 0 routes the critical request input. When 1, it drives the normal output. When 0, it drives the separate critical output. The other output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_i | input | 4 | Asynchronous external request pins, bit i is pin i |
| crit_src_i | input | 1 | Critical-class request to be routed |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| irq_req_o | output | 4 | Conditioned request per pin toward the interrupt controller |
| crit_norm_o | output | 1 | Critical request routed to the normal interrupt path |
| crit_sep_o | output | 1 | Critical request routed to the separate critical path |

## Verification
Each sense code is driven with both a rising and a falling pin change:
- In the level modes, this shows that the request follows the pin and drops when the pin does.
- In the edge modes, it separates the edge that latches from the edge that is ignored.

A latched request is then written with zeros and with a one on its clear bit, which separates a true write-one-to-clear from a plain write. With a request held in the latch, the per-pin enable and the master enable are each switched off in turn. This shows that gating acts on the output and not on the latch. A write of a mixed pattern to the spare bits, followed by a read, shows that storage and live status are merged in the read path.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int EIC_PINS   = 4;
    localparam int EIC_WORD   = 32;
    localparam int EIC_SYNC   = 2;

    localparam int POS_ROUTE  = 0;
    localparam int POS_MASTER = 12;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'b00,
        SENSE_RISE   = 2'b01,
        SENSE_FALL   = 2'b10,
        SENSE_LVL_LO = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        PIN_IDLE    = 2'b00,
        PIN_LATCHED = 2'b01,
        PIN_LEVEL   = 2'b10
    } pin_st_e;

    function automatic int en_pos(input int pin);
        return 11 - pin;
    endfunction

    function automatic int sense_pos(input int pin);
        return 22 - 2 * pin;
    endfunction

    function automatic int clr_pos(input int pin);
        return 27 - pin;
    endfunction
endpackage

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic sync_o,
    output logic prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], pin_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/eic_pin_fsm.sv
module eic_pin_fsm
    import eic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       prev_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    output logic       active_o
);
    pin_st_e st_q, st_d;
    sense_e  mode;
    logic    edge_mode;
    logic    evt;
    logic    lvl_on;

    always_comb begin
        mode      = sense_e'(sense_i);
        edge_mode = (mode == SENSE_RISE) || (mode == SENSE_FALL);
        evt       = ((mode == SENSE_RISE) && sync_i && !prev_i) ||
                    ((mode == SENSE_FALL) && !sync_i && prev_i);
        lvl_on    = ((mode == SENSE_LVL_HI) && sync_i) ||
                    ((mode == SENSE_LVL_LO) && !sync_i);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_IDLE: begin
                if (!edge_mode) st_d = lvl_on ? PIN_LEVEL : PIN_IDLE;
                else            st_d = evt ? PIN_LATCHED : PIN_IDLE;
            end
            PIN_LATCHED: begin
                if (!edge_mode) st_d = lvl_on ? PIN_LEVEL : PIN_IDLE;
                else if (evt)   st_d = PIN_LATCHED;
                else if (clr_i) st_d = PIN_IDLE;
                else            st_d = PIN_LATCHED;
            end
            PIN_LEVEL: begin
                if (!edge_mode) st_d = lvl_on ? PIN_LEVEL : PIN_IDLE;
                else            st_d = evt ? PIN_LATCHED : PIN_IDLE;
            end
            default: st_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PIN_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        active_o = (st_q != PIN_IDLE);
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && evt) |=> (st_q == PIN_LATCHED)); // R3
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && st_q == PIN_LATCHED && !clr_i) |=> (st_q == PIN_LATCHED)); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && clr_i && !evt) |=> (st_q == PIN_IDLE)); // R6
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && lvl_on) |=> (st_q == PIN_LEVEL)); // R2
endmodule

// File: rtl/eic_ctrl_reg.sv
module eic_ctrl_reg
    import eic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [EIC_WORD-1:0] wdata_i,
    input  logic [EIC_PINS-1:0] status_i,
    output logic [EIC_WORD-1:0] rdata_o,
    output logic [EIC_PINS-1:0] en_o,
    output logic [1:0]          sense_o [EIC_PINS],
    output logic [EIC_PINS-1:0] clr_o,
    output logic                master_o,
    output logic                route_o
);
    localparam logic [EIC_WORD-1:0] CLR_MASK = 32'h0F00_0000;

    logic [EIC_WORD-1:0] word_q;
    logic [EIC_WORD-1:0] live;

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (we_i) word_q <= wdata_i & ~CLR_MASK;
    end

    always_comb begin
        live = '0;
        for (int p = 0; p < EIC_PINS; p++) begin
            live[clr_pos(p)] = status_i[p];
        end
        rdata_o = (word_q & ~CLR_MASK) | live;
    end

    for (genvar p = 0; p < EIC_PINS; p++) begin : g_field
        assign en_o[p]    = word_q[en_pos(p)];
        assign sense_o[p] = word_q[sense_pos(p)+1 : sense_pos(p)];
        assign clr_o[p]   = we_i && wdata_i[clr_pos(p)];
    end

    assign master_o = word_q[POS_MASTER];
    assign route_o  = word_q[POS_ROUTE];
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
    import eic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  irq_pin_i,
    input  logic        crit_src_i,
    input  logic        reg_we_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic [3:0]  irq_req_o,
    output logic        crit_norm_o,
    output logic        crit_sep_o
);
    logic [EIC_PINS-1:0] en;
    logic [1:0]          sense [EIC_PINS];
    logic [EIC_PINS-1:0] clr;
    logic [EIC_PINS-1:0] status;
    logic                master;
    logic                route;

    eic_ctrl_reg i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .we_i     (reg_we_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .rdata_o  (reg_rdata_o),
        .en_o     (en),
        .sense_o  (sense),
        .clr_o    (clr),
        .master_o (master),
        .route_o  (route)
    );

    for (genvar p = 0; p < EIC_PINS; p++) begin : g_pin
        logic s_now;
        logic s_old;

        eic_pin_sync #(.STAGES(EIC_SYNC)) i_sync (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (irq_pin_i[p]),
            .sync_o (s_now),
            .prev_o (s_old)
        );

        eic_pin_fsm i_fsm (
            .clk      (clk),
            .rst      (rst),
            .sync_i   (s_now),
            .prev_i   (s_old),
            .sense_i  (sense[p]),
            .clr_i    (clr[p]),
            .active_o (status[p])
        );

        assign irq_req_o[p] = master && en[p] && status[p];
    end

    assign crit_norm_o = crit_src_i && route;
    assign crit_sep_o  = crit_src_i && !route;

    AST_CRIT_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
        $onehot0({crit_norm_o, crit_sep_o})); // R10
    AST_MASTER_GATES: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && !reg_wdata_i[POS_MASTER]) |=> (irq_req_o == '0)); // R8
endmodule

// File: tb/test_ext_irq_conditioner.sv
`timescale 1ns/1ps
module test_ext_irq_conditioner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pins = '0;
    logic        crit = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  req;
    logic        c_norm, c_sep;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       t_master = 1'b0;
    logic       t_route = 1'b0;
    logic [3:0] t_en = '0;
    logic [1:0] t_sense [4] = '{default: 2'b00};
    logic [31:0] t_spare = '0;

    always #4 clk = ~clk;

    ext_irq_conditioner i_ext_irq_conditioner (
        .clk (clk), .rst (rst), .irq_pin_i (pins), .crit_src_i (crit),
        .reg_we_i (we), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .irq_req_o (req), .crit_norm_o (c_norm), .crit_sep_o (c_sep)
    );

    function automatic logic [31:0] cfg_word(input logic [3:0] clrs);
        logic [31:0] w = t_spare;
        w[12] = t_master;
        w[0]  = t_route;
        for (int p = 0; p < 4; p++) begin
            w[11-p] = t_en[p];
            w[23-2*p -: 2] = t_sense[p];
            w[27-p] = clrs[p];
        end
        return w;
    endfunction

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] clrs);
        @(negedge clk);
        we = 1'b1;
        wdata = cfg_word(clrs);
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 req", {28'h0, req}, 32'h0);
        crit = 1'b1;
        #1;
        chk("R10 reset routes to separate", {30'h0, c_norm, c_sep}, 32'h1);
    endtask

    task automatic t_level_high;
        t_master = 1'b1; t_en = 4'hF;
        wr(4'h0);
        set_pin(0, 1'b1);
        chk("R2 level high follows", {28'h0, req}, 32'h1);
        set_pin(0, 1'b0);
        chk("R2 level high drops", {28'h0, req}, 32'h0);
    endtask

    task automatic t_rising;
        t_sense[1] = 2'b01;
        wr(4'h0);
        set_pin(1, 1'b1);
        chk("R3 rising latches", {28'h0, req}, 32'h2);
        set_pin(1, 1'b0);
        chk("R3 latch holds after fall", {28'h0, req}, 32'h2);
        chk("R9 status bit 26", rdata, cfg_word(4'h2));
        wr(4'h0);
        chk("R6 zero write keeps latch", {28'h0, req}, 32'h2);
    endtask

    task automatic t_gating;
        t_en[1] = 1'b0;
        wr(4'h0);
        chk("R7 disabled pin output low", {28'h0, req}, 32'h0);
        chk("R7 latch still reads", rdata, cfg_word(4'h2));
        t_en[1] = 1'b1;
        wr(4'h0);
        chk("R7 re-enabled output", {28'h0, req}, 32'h2);
        t_master = 1'b0;
        wr(4'h0);
        chk("R8 master off gates", {28'h0, req}, 32'h0);
        t_master = 1'b1;
        wr(4'h0);
        chk("R8 master on", {28'h0, req}, 32'h2);
        wr(4'h2);
        chk("R6 write one clears", {28'h0, req}, 32'h0);
        chk("R6 status cleared", rdata, cfg_word(4'h0));
    endtask

    task automatic t_falling;
        t_sense[2] = 2'b10;
        wr(4'h0);
        set_pin(2, 1'b1);
        chk("R4 rise ignored", {28'h0, req}, 32'h0);
        set_pin(2, 1'b0);
        chk("R4 fall latches", {28'h0, req}, 32'h4);
        wr(4'h4);
        chk("R6 clear pin2", {28'h0, req}, 32'h0);
    endtask

    task automatic t_level_low;
        t_sense[3] = 2'b11;
        wr(4'h0);
        @(negedge clk);
        chk("R5 low level active", {28'h0, req}, 32'h8);
        set_pin(3, 1'b1);
        chk("R5 high level idle", {28'h0, req}, 32'h0);
        set_pin(3, 1'b0);
        chk("R5 low again", {28'h0, req}, 32'h8);
        t_sense[3] = 2'b00;
        wr(4'h0);
        @(negedge clk);
        chk("R2 back to active high idle", {28'h0, req}, 32'h0);
    endtask

    task automatic t_readback;
        t_spare = 32'hA000_A0AA;
        wr(4'h0);
        chk("R9 spare bits read back", rdata, cfg_word(4'h0));
        chk("R10 route bit0 zero", {30'h0, c_norm, c_sep}, 32'h1);
        t_route = 1'b1;
        wr(4'h0);
        chk("R10 route to normal", {30'h0, c_norm, c_sep}, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_level_high;
        t_rising;
        t_gating;
        t_falling;
        t_level_low;
        t_readback;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule